// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block takes one operand as it sits in memory and rewrites it into a single unpacked form that later arithmetic can use without caring where the value came from. The source may be a signed integer of 8, 16 or 32 bits, or a binary float of 32, 64 or 96 bits. The caller presents up to three 32-bit words with a 3-bit type code and pulses a valid strobe. One clock later the block returns the unpacked result.

That result has four parts: a sign, a signed unbiased exponent, an 80-bit mantissa whose leading one sits at the top bit, and a class code. Denormal floats and integers are brought to this left-aligned form by a leading-zero count and a shift, and the exponent is reduced by the same count. Every NaN leaves the block with its quiet bit set. A NaN that arrived with the quiet bit clear is marked by its own class code, and it also sets a sticky status flag that stays set until reset.

Top module: `fp_unpack`

## Requirements
- R1: For every valid type code, the result sign equals bit 31 of the first word, for integers and floats alike.
- R2: Integer types are byte (code 0, bits 31:24 of the first word), word (code 1, bits 31:16) and long (code 2, bits 31:0), each read as two's complement. A zero value gives class zero (code 0) with exponent 0 and mantissa 0. Any other value gives class number (code 1), with the magnitude left-aligned to mantissa bit 79 and an exponent equal to the bit position of the magnitude's top one.
- R3: A float whose exponent field is all zeros and whose fraction is zero gives class zero, with exponent 0 and mantissa 0. Float types are single (code 3), double (code 4) and extended (code 5).
- R4: A float whose exponent field is neither all zeros nor all ones gives class number with exponent field − bias. The biases are 127, 1023 and 16383, and the exponent fields sit at bits 30:23, 30:20 and 30:16 of the first word. A one is placed at bit 79, and the fraction bits follow directly below it. For extended, the significand is the second word followed by the third word, and its explicit integer bit (bit 31 of the second word) is replaced by the forced one.
- R5: A single or double with a zero exponent field and a nonzero fraction gets no leading one. It starts from exponent 1 − bias and is normalized so that bit 79 is set, lowering the exponent by the shift amount.
- R6: An extended with a zero exponent field and a nonzero 64-bit significand starts from exponent −16383 with the significand placed at bits 79:16, and is then normalized.
- R7: An all-ones exponent field with a zero fraction (for extended, a zero 64-bit significand) gives class infinity (code 2) with exponent 0 and mantissa 0.
- R8: An all-ones exponent field with a nonzero fraction gives a NaN with exponent 0. The fraction bits are placed as in R5 and R6 without normalization, and mantissa bit 78 (the quiet bit) is forced to one. The class is quiet NaN (code 3) if bit 78 was already set, and signalling NaN (code 4) otherwise.
- R9: The sticky flag rises with the first signalling-NaN result and stays high through any later operands until reset.
- R10: Type codes 6 and 7 give an error output of one with sign 0, class zero, exponent 0 and mantissa 0. The sticky flag is not touched.
- R11: A valid input produces a valid output exactly one cycle later. When no input is valid, the valid output is low and the result fields keep their last values.
- R12: After reset the valid output, the error output and the sticky flag are low, and the class output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_type | input | 3 | Operand type code |
| in_word0 | input | 32 | First operand word (sign, exponent, upper fraction or integer) |
| in_word1 | input | 32 | Second operand word |
| in_word2 | input | 32 | Third operand word |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_err | output | 1 | Undefined type code |
| out_sign | output | 1 | Result sign |
| out_exp | output | 17 | Unbiased exponent, two's complement |
| out_mant | output | 80 | Mantissa, leading one at bit 79 |
| out_class | output | 3 | Class code |
| out_snan_sticky | output | 1 | Sticky signalling-NaN flag |

## Verification
Some properties are checked by assertions on every cycle: the one-cycle valid latency and the holding of result fields while idle, a top mantissa bit on every number result, zero fields for zero, infinity and error results, a set quiet bit on every NaN, and a sticky flag that never drops and is always high alongside a signalling-NaN result. Other behaviour can only be shown by the bench's scenarios against computed values. This covers the exact exponents for each bias, the denormal start exponents that differ between extended and the other formats, the placement of each format's fraction, sign extension of byte and word integers, and the way the sticky flag responds to quiet versus signalling NaNs and to reset.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

    localparam int MANT_W   = 80;
    localparam int EXP_W    = 17;
    localparam int WORD_W   = 32;
    localparam int QUIET_IX = MANT_W - 2;

    localparam int SGL_EXP  = 8;
    localparam int SGL_FRAC = 23;
    localparam int SGL_BIAS = 127;
    localparam int DBL_EXP  = 11;
    localparam int DBL_FRAC = 52;
    localparam int DBL_BIAS = 1023;
    localparam int EXT_EXP  = 15;
    localparam int EXT_SIG  = 64;
    localparam int EXT_BIAS = 16383;

    typedef enum logic [2:0] {
        OP_BYTE   = 3'd0,
        OP_WORD   = 3'd1,
        OP_LONG   = 3'd2,
        OP_SINGLE = 3'd3,
        OP_DOUBLE = 3'd4,
        OP_EXT    = 3'd5
    } optype_e;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } class_e;

    // Decoded operand before normalization
    typedef struct packed {
        class_e                   cls;
        logic signed [EXP_W-1:0]  exp;
        logic [MANT_W-1:0]        mant;
        logic                     norm;
    } pre_t;

endpackage

// File: rtl/fpu_lzc.sv
module fpu_lzc #(
    parameter int W  = 80,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpu_normalizer.sv
module fpu_normalizer #(
    parameter int MW = 80,
    parameter int EW = 17
) (
    input  logic                 enable,
    input  logic [MW-1:0]        mant_i,
    input  logic signed [EW-1:0] exp_i,
    output logic [MW-1:0]        mant_o,
    output logic signed [EW-1:0] exp_o
);
    localparam int CW = $clog2(MW + 1);

    logic [CW-1:0] lead_zeros;

    fpu_lzc #(.W(MW)) u_lzc (
        .vec (mant_i),
        .cnt (lead_zeros)
    );

    always_comb begin
        if (enable) begin
            mant_o = mant_i << lead_zeros;
            exp_o  = exp_i - $signed({{(EW - CW){1'b0}}, lead_zeros});
        end else begin
            mant_o = mant_i;
            exp_o  = exp_i;
        end
    end
endmodule

// File: rtl/fpu_int_decode.sv
module fpu_int_decode
    import fpu_unpack_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  optype_e          kind,
    input  logic [INT_W-1:0] word,
    output pre_t             pre_o
);
    localparam int PAD     = MANT_W - INT_W;
    localparam int TOP_EXP = INT_W - 1;

    logic signed [INT_W-1:0] value;
    logic [INT_W-1:0]        magnitude;

    always_comb begin
        unique case (kind)
            OP_BYTE: value = {{(INT_W - 8){word[INT_W-1]}},  word[INT_W-1 -: 8]};
            OP_WORD: value = {{(INT_W - 16){word[INT_W-1]}}, word[INT_W-1 -: 16]};
            default: value = word;
        endcase
        magnitude = value[INT_W-1] ? INT_W'(-value) : INT_W'(value);

        pre_o = '0;
        if (magnitude == '0) begin
            pre_o.cls = CLS_ZERO;
        end else begin
            pre_o.cls  = CLS_NUM;
            pre_o.exp  = EXP_W'(TOP_EXP);
            pre_o.mant = {magnitude, {PAD{1'b0}}};
            pre_o.norm = 1'b1;
        end
    end
endmodule

// File: rtl/fpu_float_decode.sv
module fpu_float_decode
    import fpu_unpack_pkg::*;
#(
    parameter int EXP_BITS     = 8,
    parameter int SIG_BITS     = 23,
    parameter int BIAS         = 127,
    parameter bit EXPLICIT_INT = 1'b0
) (
    input  logic [EXP_BITS-1:0] exp_field,
    input  logic [SIG_BITS-1:0] sig_field,
    output pre_t                pre_o
);
    localparam logic [EXP_BITS-1:0] EXP_MAX = '1;

    logic [MANT_W-1:0]       mant_raw;
    logic [MANT_W-1:0]       mant_lead;
    logic signed [EXP_W-1:0] den_exp;

    generate
        if (EXPLICIT_INT) begin : g_explicit
            localparam int PAD = MANT_W - SIG_BITS;
            assign mant_raw  = {sig_field, {PAD{1'b0}}};
            assign mant_lead = {1'b1, sig_field[SIG_BITS-2:0], {PAD{1'b0}}};
            assign den_exp   = EXP_W'(-BIAS);
        end else begin : g_implicit
            localparam int PAD = MANT_W - 1 - SIG_BITS;
            assign mant_raw  = {1'b0, sig_field, {PAD{1'b0}}};
            assign mant_lead = {1'b1, sig_field, {PAD{1'b0}}};
            assign den_exp   = EXP_W'(1 - BIAS);
        end
    endgenerate

    always_comb begin
        pre_o = '0;
        if (exp_field == '0) begin
            if (sig_field == '0) begin
                pre_o.cls = CLS_ZERO;
            end else begin
                pre_o.cls  = CLS_NUM;
                pre_o.exp  = den_exp;
                pre_o.mant = mant_raw;
                pre_o.norm = 1'b1;
            end
        end else if (exp_field == EXP_MAX) begin
            if (sig_field == '0) begin
                pre_o.cls = CLS_INF;
            end else begin
                pre_o.cls  = CLS_QNAN;
                pre_o.mant = mant_raw;
            end
        end else begin
            pre_o.cls  = CLS_NUM;
            pre_o.exp  = EXP_W'(int'(exp_field) - BIAS);
            pre_o.mant = mant_lead;
        end
    end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
    import fpu_unpack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [2:0]  in_type,
    input  logic [31:0] in_word0,
    input  logic [31:0] in_word1,
    input  logic [31:0] in_word2,
    output logic        out_valid,
    output logic        out_err,
    output logic        out_sign,
    output logic [16:0] out_exp,
    output logic [79:0] out_mant,
    output logic [2:0]  out_class,
    output logic        out_snan_sticky
);
    typedef struct packed {
        logic                    valid;
        logic                    err;
        logic                    sign;
        logic signed [EXP_W-1:0] exp;
        logic [MANT_W-1:0]       mant;
        class_e                  cls;
        logic                    sticky;
    } state_t;

    state_t st_d, st_q;

    optype_e kind;
    assign kind = optype_e'(in_type);

    pre_t int_pre, sgl_pre, dbl_pre, ext_pre, sel_pre;
    logic type_bad;

    fpu_int_decode #(.INT_W(WORD_W)) u_int (
        .kind  (kind),
        .word  (in_word0),
        .pre_o (int_pre)
    );

    fpu_float_decode #(
        .EXP_BITS(SGL_EXP), .SIG_BITS(SGL_FRAC), .BIAS(SGL_BIAS), .EXPLICIT_INT(1'b0)
    ) u_sgl (
        .exp_field (in_word0[WORD_W-2 -: SGL_EXP]),
        .sig_field (in_word0[SGL_FRAC-1:0]),
        .pre_o     (sgl_pre)
    );

    fpu_float_decode #(
        .EXP_BITS(DBL_EXP), .SIG_BITS(DBL_FRAC), .BIAS(DBL_BIAS), .EXPLICIT_INT(1'b0)
    ) u_dbl (
        .exp_field (in_word0[WORD_W-2 -: DBL_EXP]),
        .sig_field ({in_word0[DBL_FRAC-WORD_W-1:0], in_word1}),
        .pre_o     (dbl_pre)
    );

    fpu_float_decode #(
        .EXP_BITS(EXT_EXP), .SIG_BITS(EXT_SIG), .BIAS(EXT_BIAS), .EXPLICIT_INT(1'b1)
    ) u_ext (
        .exp_field (in_word0[WORD_W-2 -: EXT_EXP]),
        .sig_field ({in_word1, in_word2}),
        .pre_o     (ext_pre)
    );

    always_comb begin
        type_bad = 1'b0;
        unique case (in_type)
            OP_BYTE, OP_WORD, OP_LONG: sel_pre = int_pre;
            OP_SINGLE:                 sel_pre = sgl_pre;
            OP_DOUBLE:                 sel_pre = dbl_pre;
            OP_EXT:                    sel_pre = ext_pre;
            default: begin
                sel_pre  = '0;
                type_bad = 1'b1;
            end
        endcase
    end

    logic [MANT_W-1:0]       norm_mant;
    logic signed [EXP_W-1:0] norm_exp;

    fpu_normalizer #(.MW(MANT_W), .EW(EXP_W)) u_norm (
        .enable (sel_pre.norm),
        .mant_i (sel_pre.mant),
        .exp_i  (sel_pre.exp),
        .mant_o (norm_mant),
        .exp_o  (norm_exp)
    );

    logic snan_hit;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        snan_hit   = 1'b0;
        if (in_valid) begin
            st_d.err  = type_bad;
            st_d.sign = type_bad ? 1'b0 : in_word0[WORD_W-1];
            st_d.exp  = norm_exp;
            st_d.mant = norm_mant;
            st_d.cls  = sel_pre.cls;
            // R8: quiet every NaN, signalling ones keep their own class
            if (sel_pre.cls == CLS_QNAN && !norm_mant[QUIET_IX]) begin
                st_d.mant[QUIET_IX] = 1'b1;
                st_d.cls            = CLS_SNAN;
                snan_hit            = 1'b1;
            end
        end
        st_d.sticky = st_q.sticky | snan_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, err: 1'b0, sign: 1'b0, exp: '0,
                      mant: '0, cls: CLS_ZERO, sticky: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid       = st_q.valid;
    assign out_err         = st_q.err;
    assign out_sign        = st_q.sign;
    assign out_exp         = st_q.exp;
    assign out_mant        = st_q.mant;
    assign out_class       = st_q.cls;
    assign out_snan_sticky = st_q.sticky;

    // R11: one-cycle latency and hold while idle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_mant) && $stable(out_exp) && $stable(out_class));
    // R2, R4, R5, R6: every number leaves with its leading one at the top
    a_r4_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == CLS_NUM |-> out_mant[MANT_W-1]);
    // R3, R7: zero and infinity carry empty fields
    a_r7_empty_fields: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_class == CLS_ZERO || out_class == CLS_INF) |-> out_mant == '0 && out_exp == '0);
    // R8: no NaN leaves with the quiet bit clear
    a_r8_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_class == CLS_QNAN || out_class == CLS_SNAN) |-> out_mant[QUIET_IX]);
    // R9: sticky flag never drops and covers every signalling result
    a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        out_snan_sticky |=> out_snan_sticky);
    a_r9_sticky_on_snan: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == CLS_SNAN |-> out_snan_sticky);
    // R10: undefined type gives empty fields
    a_r10_err_fields: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_class == CLS_ZERO && out_mant == '0 && !out_sign);

endmodule

// File: tb/fp_unpack_test.sv
module fp_unpack_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_type = 3'd0;
    logic [31:0] in_word0 = '0, in_word1 = '0, in_word2 = '0;
    logic        out_valid, out_err, out_sign, out_snan_sticky;
    logic [16:0] out_exp;
    logic [79:0] out_mant;
    logic [2:0]  out_class;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fp_unpack uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_word0(in_word0), .in_word1(in_word1), .in_word2(in_word2),
        .out_valid(out_valid), .out_err(out_err), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant), .out_class(out_class),
        .out_snan_sticky(out_snan_sticky)
    );

    typedef struct packed {
        logic [2:0]  typ;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] w2;
        logic        err;
        logic        sgn;
        logic [16:0] ex;
        logic [79:0] mt;
        logic [2:0]  cl;
        logic [7:0]  req;
    } vec_t;

    localparam logic [79:0] M8 = 80'h8000_0000_0000_0000_0000;
    localparam logic [79:0] MA = 80'hA000_0000_0000_0000_0000;
    localparam logic [79:0] MC = 80'hC000_0000_0000_0000_0000;
    localparam logic [79:0] M0 = 80'h0;
    localparam int NV = 33;

    localparam vec_t VECS [NV] = '{
        // R2: integers
        '{3'd2, 32'h0000_0001, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  M8, 3'd1, 8'd2},
        '{3'd2, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b1, 17'd0,  M8, 3'd1, 8'd1},  // R1
        '{3'd0, 32'h0500_00AB, 32'h0, 32'h0, 1'b0, 1'b0, 17'd2,  MA, 3'd1, 8'd2},
        '{3'd0, 32'h8012_3456, 32'h0, 32'h0, 1'b0, 1'b1, 17'd7,  M8, 3'd1, 8'd2},
        '{3'd0, 32'hFF00_0000, 32'h0, 32'h0, 1'b0, 1'b1, 17'd0,  M8, 3'd1, 8'd2},
        '{3'd1, 32'h0003_FFFF, 32'h0, 32'h0, 1'b0, 1'b0, 17'd1,  MC, 3'd1, 8'd2},
        '{3'd1, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b1, 17'd15, M8, 3'd1, 8'd2},
        '{3'd2, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b1, 17'd31, M8, 3'd1, 8'd2},
        '{3'd2, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  M0, 3'd0, 8'd2},
        '{3'd1, 32'h0000_FFFF, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  M0, 3'd0, 8'd2},
        // R4: single normals
        '{3'd3, 32'h3F80_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  M8, 3'd1, 8'd4},
        '{3'd3, 32'hC020_0000, 32'h0, 32'h0, 1'b0, 1'b1, 17'd1,  MA, 3'd1, 8'd4},
        // R3: zeros
        '{3'd3, 32'h0000_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  M0, 3'd0, 8'd3},
        '{3'd3, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b1, 17'd0,  M0, 3'd0, 8'd3},
        // R5: single denormals
        '{3'd3, 32'h0000_0001, 32'h0, 32'h0, 1'b0, 1'b0, 17'(-149), M8, 3'd1, 8'd5},
        '{3'd3, 32'h0040_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'(-127), M8, 3'd1, 8'd5},
        // R7: single infinities
        '{3'd3, 32'h7F80_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  M0, 3'd2, 8'd7},
        '{3'd3, 32'hFF80_0000, 32'h0, 32'h0, 1'b0, 1'b1, 17'd0,  M0, 3'd2, 8'd7},
        // R8: single NaNs
        '{3'd3, 32'h7FC0_0001, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  80'h4000_0100_0000_0000_0000, 3'd3, 8'd8},
        '{3'd3, 32'h7F80_0001, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  80'h4000_0100_0000_0000_0000, 3'd4, 8'd8},
        // R4, R5, R7, R8: double
        '{3'd4, 32'h3FF0_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  M8, 3'd1, 8'd4},
        '{3'd4, 32'h4008_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'd1,  MC, 3'd1, 8'd4},
        '{3'd4, 32'h0000_0000, 32'h1, 32'h0, 1'b0, 1'b0, 17'(-1074), M8, 3'd1, 8'd5},
        '{3'd4, 32'h7FF0_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0,  M0, 3'd2, 8'd7},
        '{3'd4, 32'h7FF0_0000, 32'h1, 32'h0, 1'b0, 1'b0, 17'd0,  80'h4000_0000_0000_0800_0000, 3'd4, 8'd8},
        // R4, R6, R3, R7, R8: extended
        '{3'd5, 32'h3FFF_0000, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 17'd0, M8, 3'd1, 8'd4},
        '{3'd5, 32'h4000_0000, 32'h4000_0000, 32'h0, 1'b0, 1'b0, 17'd1, MC, 3'd1, 8'd4},
        '{3'd5, 32'h0000_0000, 32'h0, 32'h1, 1'b0, 1'b0, 17'(-16446), M8, 3'd1, 8'd6},
        '{3'd5, 32'h0000_0000, 32'h4000_0000, 32'h0, 1'b0, 1'b0, 17'(-16384), M8, 3'd1, 8'd6},
        '{3'd5, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b1, 17'd0, M0, 3'd0, 8'd3},
        '{3'd5, 32'h7FFF_0000, 32'h0, 32'h0, 1'b0, 1'b0, 17'd0, M0, 3'd2, 8'd7},
        '{3'd5, 32'h7FFF_0000, 32'hC000_0000, 32'h5, 1'b0, 1'b0, 17'd0, 80'hC000_0000_0000_0005_0000, 3'd3, 8'd8},
        // R10: undefined type
        '{3'd6, 32'hFFFF_FFFF, 32'h1, 32'h1, 1'b1, 1'b0, 17'd0, M0, 3'd0, 8'd10}
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input logic [2:0] t, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        in_type  = t;
        in_word0 = a;
        in_word1 = b;
        in_word2 = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] act, expv;
        logic [79:0]  held_mant;

        // R12: reset state
        @(negedge clk);
        @(negedge clk);
        check(!out_valid && !out_err && !out_snan_sticky && out_class == 3'd0, "R12",
              {out_valid, out_err, out_snan_sticky, out_class},
              128'h0);
        rst_n = 1'b1;

        // Table walk: R1 to R8, R10, R11
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].typ, VECS[i].w0, VECS[i].w1, VECS[i].w2);
            act  = {out_err, out_sign, out_exp, out_mant, out_class};
            expv = {VECS[i].err, VECS[i].sgn, VECS[i].ex, VECS[i].mt, VECS[i].cl};
            check(out_valid && act == expv, $sformatf("R%0d vector %0d", VECS[i].req, i), act, expv);
        end

        // R10: type 7 also rejected
        drive(3'd7, 32'h3F80_0000, 32'h0, 32'h0);
        check(out_err && out_class == 3'd0 && out_mant == '0 && !out_sign, "R10 type7",
              {out_err, out_sign, out_class}, {1'b1, 1'b0, 3'd0});

        // R11: fields hold while idle
        drive(3'd3, 32'hC020_0000, 32'h0, 32'h0);
        held_mant = out_mant;
        @(negedge clk);
        in_type  = 3'd2;
        in_word0 = 32'h1234_5678;
        @(negedge clk);
        check(!out_valid && out_mant == held_mant && out_class == 3'd1 && out_exp == 17'd1,
              "R11 hold", {out_valid, out_mant}, {1'b0, held_mant});

        // R9: sticky behaviour
        do_reset();
        drive(3'd3, 32'h7FC0_0000, 32'h0, 32'h0);
        check(out_class == 3'd3 && !out_snan_sticky, "R9 quiet NaN leaves flag low",
              {out_class, out_snan_sticky}, {3'd3, 1'b0});
        drive(3'd6, 32'h0, 32'h0, 32'h0);
        check(!out_snan_sticky, "R9 R10 error leaves flag low", out_snan_sticky, 1'b0);
        drive(3'd4, 32'hFFF4_0000, 32'h0, 32'h0);
        check(out_class == 3'd4 && out_snan_sticky && out_sign, "R9 signalling sets flag",
              {out_class, out_snan_sticky}, {3'd4, 1'b1});
        drive(3'd3, 32'h3F80_0000, 32'h0, 32'h0);
        check(out_class == 3'd1 && out_snan_sticky, "R9 flag stays after number",
              {out_class, out_snan_sticky}, {3'd1, 1'b1});
        do_reset();
        check(!out_snan_sticky && !out_valid, "R12 reset clears flag",
              {out_valid, out_snan_sticky}, 2'b00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule